// File: doc/BRIEF.md
# Configurable single-port synchronous RAM

This block is a single-port synchronous memory with byte-lane writes. Address, write data, write enable, lane enables and read enable are sampled at the rising clock edge. That edge also performs the access: the write, if any, and the capture of the read word into a read stage. An optional output register adds a second stage in front of `q`.

The caller picks, through parameters, how a read of the word being written behaves:

- the freshly merged word;
- the word as it stood before the write;
- an unknown value.

Other parameters choose whether the input and output clock enables, the address hold, the read enable and the asynchronous clear take effect. They also choose whether the clear empties the output path and whether unwritten lanes read back as unknown during a write. The memory array itself is never cleared.

Top module: `sp_ram`

## Requirements
- R1: A read issued at a clock edge shows on `q` after that edge when OUT_REG=0. When OUT_REG=1 it shows one edge later, provided `out_ce` is high at that later edge.
- R2: Bit i of `lane_en` guards `wdata[8*i+7:8*i]`. A write changes only the lanes whose bit is 1; the other lanes of the word keep their contents.
- R3: With RDW_MODE=0, a read of the word being written returns the merged result: new bytes in the enabled lanes, and stored bytes in the others when MASKED_X=0. With MASKED_X=1 the other lanes are unknown.
- R4: With RDW_MODE=1, a read of the word being written returns the contents stored before that write.
- R5: With RDW_MODE=2, the read stage is unknown after a read of the word being written. Reads at all other edges return the stored word.
- R6: With `rd_en` low at an edge, the read stage keeps its value.
- R7: With `addr_hold` high at an edge where the input enable is high, the access uses the last captured address instead of `addr`.
- R8: With `in_ce` low at an edge, no write occurs, the read stage holds and the captured address holds.
- R9: With OUT_REG=1 and `out_ce` low at an edge, `q` holds.
- R10: A high level on `clr` sets the captured address to 0 at once. When CLEAR_Q=1 it also forces `q` and the read stage to 0 at once. When CLEAR_Q=0, `q` is not affected. Memory contents survive the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| clr | input | 1 | Asynchronous clear, active high |
| in_ce | input | 1 | Clock enable of the input side and the access |
| out_ce | input | 1 | Clock enable of the output register |
| addr_hold | input | 1 | When high, reuse the last captured address |
| rd_en | input | 1 | Read enable |
| wr_en | input | 1 | Write enable |
| lane_en | input | LANES | Per-byte write enables, bit i for lane i |
| addr | input | ADDR_W | Word address |
| wdata | input | 8*LANES | Write data |
| q | output | 8*LANES | Read data |

## Verification
The assertions rely on `clr` changing away from clock edges and on every control input being a known 0 or 1 at each edge. They also assume an X from the unknown read-during-write result reaches only the data path, never a control signal. The stimulus drives all inputs at the falling edge from a clean reset. It fills the whole array before the first read so that no uninitialised word is ever compared. The unknown-result instance is compared only on edges where the reference model knows the word is defined.

// File: rtl/sp_ram.sv
`timescale 1ns/1ps
module sp_ram #(
  parameter int ADDR_W         = 6,
  parameter int LANES          = 4,
  parameter int OUT_REG        = 1,
  parameter int USE_IN_CE      = 1,
  parameter int USE_OUT_CE     = 1,
  parameter int USE_ADDR_STALL = 1,
  parameter int USE_RDEN       = 1,
  parameter int USE_CLR        = 1,
  parameter int CLEAR_Q        = 1,
  parameter int RDW_MODE       = 0,
  parameter int MASKED_X       = 0
) (
  input  logic                 clk,
  input  logic                 clr,
  input  logic                 in_ce,
  input  logic                 out_ce,
  input  logic                 addr_hold,
  input  logic                 rd_en,
  input  logic                 wr_en,
  input  logic [LANES-1:0]     lane_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [8*LANES-1:0]   wdata,
  output logic [8*LANES-1:0]   q
);
  localparam int DW    = 8 * LANES;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0]     mem [DEPTH];
  logic [ADDR_W-1:0] addr_q, addr_use;
  logic [DW-1:0]     old_word, new_word, rdw_word, rd_val, rd_stage;
  logic              go_in, go_out, rd_ok, stall, clr_on, clr_q;

  assign go_in    = (USE_IN_CE == 0) || in_ce;
  assign go_out   = (USE_OUT_CE == 0) || out_ce;
  assign rd_ok    = (USE_RDEN == 0) || rd_en;
  assign stall    = (USE_ADDR_STALL != 0) && addr_hold;
  assign clr_on   = (USE_CLR != 0) && clr;
  assign clr_q    = clr_on && (CLEAR_Q != 0);
  assign addr_use = stall ? addr_q : addr;
  assign old_word = mem[addr_use];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign new_word[8*i +: 8] = lane_en[i] ? wdata[8*i +: 8] : old_word[8*i +: 8];
    if (MASKED_X != 0) begin : g_x
      assign rdw_word[8*i +: 8] = lane_en[i] ? wdata[8*i +: 8] : 8'bx;
    end else begin : g_old
      assign rdw_word[8*i +: 8] = new_word[8*i +: 8];
    end
  end

  always_comb begin
    if (!wr_en) rd_val = old_word;
    else begin
      case (RDW_MODE)
        0:       rd_val = rdw_word;
        1:       rd_val = old_word;
        default: rd_val = 'x;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (go_in && wr_en) mem[addr_use] <= new_word;

  always_ff @(posedge clk or posedge clr_on)
    if (clr_on)     addr_q <= '0;
    else if (go_in) addr_q <= addr_use;

  always_ff @(posedge clk or posedge clr_q)
    if (clr_q)               rd_stage <= '0;
    else if (go_in && rd_ok) rd_stage <= rd_val;

  if (OUT_REG != 0) begin : g_oreg
    logic [DW-1:0] out_stage;
    always_ff @(posedge clk or posedge clr_q)
      if (clr_q)       out_stage <= '0;
      else if (go_out) out_stage <= rd_stage;
    assign q = out_stage;
  end else begin : g_noreg
    assign q = rd_stage;
  end
endmodule

module sp_ram_chk #(
  parameter int ADDR_W = 6, LANES = 4, OUT_REG = 1, USE_IN_CE = 1, USE_OUT_CE = 1,
  parameter int USE_ADDR_STALL = 1, USE_RDEN = 1, USE_CLR = 1, CLEAR_Q = 1, RDW_MODE = 0
) (
  input logic               clk, clr, in_ce, out_ce, addr_hold, rd_en, wr_en,
  input logic [LANES-1:0]   lane_en,
  input logic [8*LANES-1:0] wdata, q, rd_stage,
  input logic [ADDR_W-1:0]  addr_q
);
  logic go, rd;
  assign go = (USE_IN_CE == 0) || in_ce;
  assign rd = (USE_RDEN == 0) || rd_en;

  // R10
  always @(posedge clk)
    if (USE_CLR != 0 && CLEAR_Q != 0 && clr) q_clear_chk: assert (q == '0);

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (clr)
    (OUT_REG != 0 && USE_OUT_CE != 0 && !out_ce) |=> $stable(q));

  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (clr)
    !(go && rd) |=> $stable(rd_stage));

  // R7
  addr_stall_chk: assert property (@(posedge clk) disable iff (clr)
    (USE_ADDR_STALL != 0 && addr_hold) |=> $stable(addr_q));

  // R8
  ce_off_chk: assert property (@(posedge clk) disable iff (clr)
    (USE_IN_CE != 0 && !in_ce) |=> ($stable(addr_q) && $stable(rd_stage)));

  // R3
  new_full_chk: assert property (@(posedge clk) disable iff (clr)
    (RDW_MODE == 0 && go && rd && wr_en && (&lane_en)) |=> (rd_stage == $past(wdata)));
endmodule

bind sp_ram sp_ram_chk #(
  .ADDR_W(ADDR_W), .LANES(LANES), .OUT_REG(OUT_REG), .USE_IN_CE(USE_IN_CE),
  .USE_OUT_CE(USE_OUT_CE), .USE_ADDR_STALL(USE_ADDR_STALL), .USE_RDEN(USE_RDEN),
  .USE_CLR(USE_CLR), .CLEAR_Q(CLEAR_Q), .RDW_MODE(RDW_MODE)
) chk (
  .clk(clk), .clr(clr), .in_ce(in_ce), .out_ce(out_ce), .addr_hold(addr_hold),
  .rd_en(rd_en), .wr_en(wr_en), .lane_en(lane_en), .wdata(wdata), .q(q),
  .rd_stage(rd_stage), .addr_q(addr_q)
);

// File: tb/sp_ram_test.sv
`timescale 1ns/1ps
module sp_ram_test;
  logic clk = 0, clr = 0, in_ce = 0, out_ce = 0, addr_hold = 0, rd_en = 0, wr_en = 0;
  logic [3:0]  lane_en = 0;
  logic [5:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] qa, qb, qc;
  int total = 0, bad = 0;
  string tag = "R10";
  bit started = 0;

  always #2 clk = ~clk;

  sp_ram #(.OUT_REG(1), .CLEAR_Q(1), .RDW_MODE(0)) uut (.clk(clk), .clr(clr), .in_ce(in_ce),
    .out_ce(out_ce), .addr_hold(addr_hold), .rd_en(rd_en), .wr_en(wr_en), .lane_en(lane_en),
    .addr(addr), .wdata(wdata), .q(qa));
  sp_ram #(.OUT_REG(0), .CLEAR_Q(0), .RDW_MODE(1)) uut_b (.clk(clk), .clr(clr), .in_ce(in_ce),
    .out_ce(out_ce), .addr_hold(addr_hold), .rd_en(rd_en), .wr_en(wr_en), .lane_en(lane_en),
    .addr(addr), .wdata(wdata), .q(qb));
  sp_ram #(.OUT_REG(0), .CLEAR_Q(1), .RDW_MODE(2)) uut_c (.clk(clk), .clr(clr), .in_ce(in_ce),
    .out_ce(out_ce), .addr_hold(addr_hold), .rd_en(rd_en), .wr_en(wr_en), .lane_en(lane_en),
    .addr(addr), .wdata(wdata), .q(qc));

  logic [31:0] ref_mem [64];
  logic [31:0] qa0 = 0, qa1 = 0, qb0 = 0, qc0 = 0;
  logic [5:0]  ra = 0;
  bit b_valid = 0, c_dc = 0;

  function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] w, logic [3:0] be);
    for (int i = 0; i < 4; i++) if (be[i]) o[8*i +: 8] = w[8*i +: 8];
    return o;
  endfunction

  task automatic check(string r, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h at %0t", r, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    logic [5:0] a;
    logic [31:0] o, n, nqa0;
    if (clr) begin
      ra = 0; qa0 = 0; qa1 = 0; qc0 = 0; c_dc = 0;
    end else begin
      nqa0 = qa0;
      if (in_ce) begin
        a = addr_hold ? ra : addr;
        o = ref_mem[a];
        n = merge(o, wdata, lane_en);
        if (rd_en) begin
          nqa0 = wr_en ? n : o;
          qb0 = o; qc0 = o; c_dc = wr_en; b_valid = 1;
        end
        if (wr_en) ref_mem[a] = n;
        ra = a;
      end
      if (out_ce) qa1 = qa0;
      qa0 = nqa0;
    end
  end

  always @(negedge clk)
    if (started && !clr) begin
      check(tag, qa, qa1);
      if (b_valid) check(tag == "R3" ? "R4" : tag, qb, qb0);
      if (b_valid && !c_dc) check("R5", qc, qc0);
    end

  task automatic drive(logic [5:0] a, logic [31:0] w, logic [3:0] be, bit we, bit re,
                       bit hold, bit ice, bit oce);
    @(negedge clk);
    addr = a; wdata = w; lane_en = be; wr_en = we; rd_en = re;
    addr_hold = hold; in_ce = ice; out_ce = oce;
  endtask

  task automatic rnd(int n, int p_we, int p_re, int p_hold, int p_ice, int p_oce, bit full);
    for (int k = 0; k < n; k++)
      drive(6'($urandom), $urandom, full ? 4'hf : 4'($urandom),
            ($urandom % 100) < p_we, ($urandom % 100) < p_re, ($urandom % 100) < p_hold,
            ($urandom % 100) < p_ice, ($urandom % 100) < p_oce);
  endtask

  initial begin
    logic [31:0] keep;
    #1 clr = 1;
    repeat (2) @(negedge clk);
    check("R10", qa, 32'h0);
    clr = 0;
    started = 1;
    tag = "R2";
    for (int i = 0; i < 64; i++) drive(6'(i), 32'(i) * 32'h01030507 ^ 32'h9e3779b9, 4'hf, 1, 0, 0, 1, 1);
    tag = "R1";
    for (int i = 0; i < 64; i++) drive(6'(i), 0, 0, 0, 1, 0, 1, 1);
    tag = "R3";
    rnd(200, 60, 100, 0, 100, 100, 1);
    tag = "R2";
    rnd(200, 60, 100, 0, 100, 100, 0);
    tag = "R6";
    rnd(200, 40, 40, 0, 100, 100, 0);
    tag = "R7";
    rnd(200, 40, 80, 50, 100, 100, 0);
    tag = "R8";
    rnd(200, 50, 80, 10, 40, 100, 0);
    tag = "R9";
    rnd(200, 30, 80, 10, 100, 40, 0);
    drive(6'd5, 0, 0, 0, 1, 0, 1, 1);
    drive(6'd9, 0, 0, 0, 1, 0, 1, 1);
    drive(6'd9, 0, 0, 0, 1, 0, 1, 1);
    @(negedge clk);
    keep = qb;
    clr = 1;
    #1;
    check("R10", qa, 32'h0);
    check("R10", qb, keep);
    repeat (2) @(negedge clk);
    clr = 0;
    tag = "R10";
    drive(6'd0, 0, 0, 0, 1, 1, 1, 1);
    for (int i = 0; i < 64; i++) drive(6'(i), 0, 0, 0, 1, 0, 1, 1);
    tag = "R1";
    rnd(400, 30, 70, 10, 85, 85, 0);
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog: got hang expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule